// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Register File

This block is a watchdog countdown placed behind a small register file. A prescaler divides the system clock into periodic ticks. A 10-bit down-counter, loaded from a programmable timeout register, is decremented on each tick. Software keeps the system alive by writing the reload register before the count runs out.

Each expiry sets a status flag and may pulse a system event line. The block asks for a system reset only on the second expiry in a row, and only if neither the safe-mode strap nor the reboot-inhibit input blocks it. The register file also holds two mailbox bytes. Writing the inbound mailbox sets a flag and pulses the event line. Writing the outbound mailbox sets a different flag.

Register accesses are plain single-cycle transfers with no valid/ready handshake, because the block never stalls. A write is accepted on the rising edge where `bus_wr` is high. Read data is a combinational function of the address and size, and it is valid in the same cycle.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset the timer is stopped and the registers read as follows: timeout (0x10) = 0x0004, control 2 (0x0A) = 0x0008, software-interrupt byte (0x12) = 0x03, and every other register = 0. `sys_event` and `reset_req` are low.
- R2: The countdown starts only when the halt bit (bit 0 of control 1 at 0x08) is clear and the timeout value is greater than 1. A timeout of 0 or 1 never starts the timer.
- R3: A start makes the first expiry happen exactly timeout × TICK_DIV cycles after the starting write. Each expiry sets bit 0 of status 1 (0x04) and reloads the count from the timeout register.
- R4: An expiry that does not cause a reset drives `sys_event` high for one cycle when `event_en` is high, and leaves it low when `event_en` is low.
- R5: On the second consecutive expiry, bits 0 and 1 of status 2 (0x06) are set. If `strap_safe` and `reboot_inhibit` are both low, `reset_req` goes high and stays high until reset. In that case the timer stops, the reload register reads 0, and no event pulse is produced.
- R6: If `strap_safe` or `reboot_inhibit` blocks the reset, the second expiry behaves like a first one, with an event pulse and a reload. The consecutive count then restarts, so the third expiry counts as a first.
- R7: A write to the reload register (0x00) clears the consecutive-expiry count. If the run condition holds, it restarts the countdown from the timeout value. Otherwise it stores the written value.
- R8: A write to control 1 starts or restarts the countdown if the run condition holds under the new halt bit, and stops the countdown otherwise.
- R9: The lock bit (bit 1 of control 1) can be set by a write. A later write cannot clear it; only reset does.
- R10: While the timer runs, reading the reload register returns the remaining tick count. While it is stopped, the read returns the stored value.
- R11: A write to the inbound mailbox byte (0x02) sets bit 2 of status 1 and pulses `sys_event` whatever the state of `event_en`. A write to the outbound mailbox byte (0x03) sets bit 1 of status 1.
- R12: Accesses are 1 or 2 bytes wide and little-endian. A halfword covers the even address and the address after it. A byte read returns the addressed byte in bits 7:0. Writes are masked: status 1 to 0x0007, status 2 to 0x0003, control 1 to 0x0003, and the byte at 0x0E to 0x00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_rdata | output | 16 | Combinational read data |
| strap_safe | input | 1 | When high, blocks the reset request |
| reboot_inhibit | input | 1 | When high, blocks the reset request |
| event_en | input | 1 | Enables the event pulse on an expiry |
| sys_event | output | 1 | One-cycle event pulse |
| reset_req | output | 1 | Sticky system-reset request |

## Verification
The in-RTL assertions check the following on every cycle:
- the lock bit and the reset request never fall;
- a start never happens with a timeout below 2;
- a halting write always stops the counter;
- an expiry reloads the count and sets the timeout flag;
- a firing expiry stops the timer with no event pulse;
- an inbound mailbox write produces the flag and the pulse.

Some behaviour can only be shown by the bench's scenarios:
- the exact expiry cycle for a given timeout and divider;
- the live count read back mid-period;
- the stored reload value when stopped;
- clearing of the consecutive count by a reload write;
- the blocked second expiry rolling over into a fresh first;
- byte-lane placement and masking of writes.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int TMO_W    = 10;
  localparam int NUM_HW   = 10;
  localparam int HW_IDX_W = 4;
  localparam int BUS_AW   = HW_IDX_W + 1;

  // halfword slots; the byte address is twice the slot index
  localparam int HW_RLD   = 0;
  localparam int HW_MBOX  = 1;
  localparam int HW_STAT1 = 2;
  localparam int HW_STAT2 = 3;
  localparam int HW_CTRL1 = 4;
  localparam int HW_CTRL2 = 5;
  localparam int HW_MSG   = 6;
  localparam int HW_WDCNT = 7;
  localparam int HW_TMO   = 8;
  localparam int HW_SWIRQ = 9;

  localparam int S1_TIMEOUT = 0;
  localparam int S1_OUTBOX  = 1;
  localparam int S1_SWEVT   = 2;
  localparam int S2_SECOND  = 0;
  localparam int S2_BOOT    = 1;
  localparam int C1_HALT    = 0;
  localparam int C1_LOCK    = 1;

  function automatic logic [15:0] hw_mask(input int idx, input int cnt_w);
    case (idx)
      HW_STAT1:           return 16'h0007;
      HW_STAT2:           return 16'h0003;
      HW_CTRL1:           return 16'h0003;
      HW_WDCNT, HW_SWIRQ: return 16'h00FF;
      HW_TMO:             return 16'((32'd1 << cnt_w) - 32'd1);
      default:            return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] hw_reset(input int idx);
    case (idx)
      HW_TMO:   return 16'h0004;
      HW_CTRL2: return 16'h0008;
      HW_SWIRQ: return 16'h0003;
      default:  return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr || tick)   cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             clr_consec,
  input  logic [CNT_W-1:0] timeout_val,
  input  logic             block_fire,
  output logic             running,
  output logic [CNT_W-1:0] live_cnt,
  output logic             expire_now,
  output logic             second_now,
  output logic             fire_now
);
  logic consec_q;

  assign expire_now = running && tick && (live_cnt <= CNT_W'(1)) && !start && !stop;
  assign second_now = expire_now && consec_q;
  assign fire_now   = second_now && !block_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      live_cnt <= '0;
    end else if (start) begin
      running  <= 1'b1;
      live_cnt <= timeout_val;
    end else if (stop) begin
      running  <= 1'b0;
    end else if (expire_now) begin
      running  <= !fire_now;
      live_cnt <= fire_now ? '0 : timeout_val;
    end else if (running && tick) begin
      live_cnt <= live_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          consec_q <= 1'b0;
    else if (clr_consec) consec_q <= 1'b0;
    else if (expire_now) consec_q <= !consec_q;
  end

  assert_start_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (timeout_val > CNT_W'(1)));
  assert_reload_on_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_now && !fire_now) |=> (running && live_cnt == $past(timeout_val)));
  assert_fire_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_now |=> !running);
endmodule

// File: rtl/dual_stage_wdt.sv
`timescale 1ns/1ps
module dual_stage_wdt
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int CNT_W    = TMO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_half,
  output logic [15:0]       bus_rdata,
  input  logic              strap_safe,
  input  logic              reboot_inhibit,
  input  logic              event_en,
  output logic              sys_event,
  output logic              reset_req
);
  logic [HW_IDX_W-1:0] hw_idx;
  logic                lane_sel, idx_ok, be_lo, be_hi;
  logic [7:0]          lane_lo, lane_hi;
  logic [15:0]         cur, merged;
  logic [15:0]         hw_q [NUM_HW];
  logic [15:0]         hw_d [NUM_HW];
  logic [NUM_HW-1:0]   wr_hit;

  assign hw_idx   = bus_addr[BUS_AW-1:1];
  assign lane_sel = bus_addr[0];
  assign idx_ok   = hw_idx < HW_IDX_W'(NUM_HW);
  assign be_lo    = bus_half || !lane_sel;
  assign be_hi    = bus_half || lane_sel;
  assign lane_lo  = bus_wdata[7:0];
  assign lane_hi  = bus_half ? bus_wdata[15:8] : bus_wdata[7:0];
  assign cur      = idx_ok ? hw_q[hw_idx] : 16'h0000;
  assign merged   = {be_hi ? lane_hi : cur[15:8], be_lo ? lane_lo : cur[7:0]};

  for (genvar g = 0; g < NUM_HW; g++) begin : g_hit
    assign wr_hit[g] = bus_wr && idx_ok && (hw_idx == HW_IDX_W'(g));
  end

  // run control
  logic             tick, start, stop, rld_wr, ctl_wr, mbox_in_wr, mbox_out_wr;
  logic             tmo_ok, halt_now, halt_new;
  logic             running, expire_now, second_now, fire_now;
  logic [CNT_W-1:0] tmo_val, live_cnt;

  assign tmo_val     = hw_q[HW_TMO][CNT_W-1:0];
  assign tmo_ok      = tmo_val > CNT_W'(1);
  assign halt_now    = hw_q[HW_CTRL1][C1_HALT];
  assign halt_new    = merged[C1_HALT];
  assign rld_wr      = wr_hit[HW_RLD];
  assign ctl_wr      = wr_hit[HW_CTRL1];
  assign start       = tmo_ok && ((rld_wr && !halt_now) || (ctl_wr && !halt_new));
  assign stop        = ctl_wr && !start;
  assign mbox_in_wr  = wr_hit[HW_MBOX] && be_lo;
  assign mbox_out_wr = wr_hit[HW_MBOX] && be_hi;

  wdt_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(start), .tick(tick)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
    .clr_consec(rld_wr), .timeout_val(tmo_val),
    .block_fire(strap_safe || reboot_inhibit),
    .running(running), .live_cnt(live_cnt), .expire_now(expire_now),
    .second_now(second_now), .fire_now(fire_now)
  );

  // register next state
  always_comb begin
    for (int i = 0; i < NUM_HW; i++) begin
      hw_d[i] = wr_hit[i] ? (merged & hw_mask(i, CNT_W)) : hw_q[i];
    end
    if (expire_now) hw_d[HW_RLD] = fire_now ? 16'h0000 : 16'(tmo_val);
    if (start)      hw_d[HW_RLD] = 16'(tmo_val);
    hw_d[HW_CTRL1][C1_LOCK] = hw_d[HW_CTRL1][C1_LOCK] | hw_q[HW_CTRL1][C1_LOCK];
    if (expire_now)  hw_d[HW_STAT1][S1_TIMEOUT] = 1'b1;
    if (mbox_out_wr) hw_d[HW_STAT1][S1_OUTBOX]  = 1'b1;
    if (mbox_in_wr)  hw_d[HW_STAT1][S1_SWEVT]   = 1'b1;
    if (second_now) begin
      hw_d[HW_STAT2][S2_SECOND] = 1'b1;
      hw_d[HW_STAT2][S2_BOOT]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_HW; i++) hw_q[i] <= hw_reset(i);
      sys_event <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      hw_q      <= hw_d;
      sys_event <= (expire_now && !fire_now && event_en) || mbox_in_wr;
      reset_req <= reset_req || fire_now;
    end
  end

  // read path
  logic [15:0] rd_hw;
  always_comb begin
    rd_hw = cur;
    if (hw_idx == HW_IDX_W'(HW_RLD) && running) rd_hw = 16'(live_cnt);
    if (bus_half)      bus_rdata = rd_hw;
    else if (lane_sel) bus_rdata = {8'h00, rd_hw[15:8]};
    else               bus_rdata = {8'h00, rd_hw[7:0]};
  end

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_q[HW_CTRL1][C1_LOCK] |=> hw_q[HW_CTRL1][C1_LOCK]);
  assert_reset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);
  assert_fire_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_now && !mbox_in_wr) |=> (reset_req && !sys_event));
  assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && halt_new) |=> !running);
  assert_timeout_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_now |=> hw_q[HW_STAT1][S1_TIMEOUT]);
  assert_mbox_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_in_wr |=> (sys_event && hw_q[HW_STAT1][S1_SWEVT]));
endmodule

// File: tb/test_dual_stage_wdt.sv
`timescale 1ns/1ps
module test_dual_stage_wdt;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_half = 1'b1;
  logic [15:0] bus_rdata;
  logic        strap_safe = 1'b0;
  logic        reboot_inhibit = 1'b0;
  logic        event_en = 1'b1;
  logic        sys_event, reset_req;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dual_stage_wdt #(.TICK_DIV(DIV)) i_dual_stage_wdt (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_half(bus_half), .bus_rdata(bus_rdata),
    .strap_safe(strap_safe), .reboot_inhibit(reboot_inhibit),
    .event_en(event_en), .sys_event(sys_event), .reset_req(reset_req)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     rd_ev;

  function automatic void chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // monitor: pops expected read results and compares
  initial begin
    forever begin
      @(rd_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  // driver tasks
  task automatic rd_expect(input logic [4:0] a, input logic h, input logic [15:0] e, input string tag);
    sb_item_t it;
    bus_addr = a;
    bus_half = h;
    #0.5;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    -> rd_ev;
    #0.5;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic h);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_half = h; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wn(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wn(3);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 event low", 16'(sys_event), 16'd0);
    chk("R1 reset_req low", 16'(reset_req), 16'd0);
    rd_expect(5'h10, 1'b1, 16'h0004, "R1 timeout reset");
    rd_expect(5'h0A, 1'b1, 16'h0008, "R1 control2 reset");
    rd_expect(5'h12, 1'b0, 16'h0003, "R1 swirq reset");
    rd_expect(5'h04, 1'b1, 16'h0000, "R1 status1 reset");
    wn(20);
    rd_expect(5'h00, 1'b1, 16'h0000, "R1 timer idle after reset");

    // R12 byte lanes and masks
    wr(5'h0C, 16'h00A5, 1'b0);
    wr(5'h0D, 16'h005A, 1'b0);
    rd_expect(5'h0C, 1'b1, 16'h5AA5, "R12 halfword of two bytes");
    rd_expect(5'h0D, 1'b0, 16'h005A, "R12 odd byte read");
    wr(5'h0E, 16'hBEEF, 1'b1);
    rd_expect(5'h0E, 1'b1, 16'h00EF, "R12 byte reg mask");
    wr(5'h04, 16'hFFFF, 1'b1);
    rd_expect(5'h04, 1'b1, 16'h0007, "R12 status1 mask");
    wr(5'h06, 16'hFFFF, 1'b1);
    rd_expect(5'h06, 1'b1, 16'h0003, "R12 status2 mask");
    wr(5'h04, 16'h0000, 1'b1);
    wr(5'h06, 16'h0000, 1'b1);

    // R7 / R10 stored value while halted, R2 halt blocks
    wr(5'h08, 16'h0001, 1'b1);
    rd_expect(5'h08, 1'b1, 16'h0001, "R12 control1 write");
    wr(5'h00, 16'h0123, 1'b1);
    rd_expect(5'h00, 1'b1, 16'h0123, "R7 stored when halted");
    wn(20);
    rd_expect(5'h00, 1'b1, 16'h0123, "R10 stopped read stored");
    rd_expect(5'h04, 1'b1, 16'h0000, "R2 halted no expiry");

    // R2 timeout of 1 and 0 never start
    wr(5'h10, 16'h0001, 1'b1);
    wr(5'h08, 16'h0000, 1'b1);
    wn(20);
    rd_expect(5'h00, 1'b1, 16'h0123, "R2 timeout 1 not running");
    rd_expect(5'h04, 1'b1, 16'h0000, "R2 timeout 1 no expiry");
    wr(5'h10, 16'h0000, 1'b1);
    wr(5'h00, 16'h0055, 1'b1);
    rd_expect(5'h00, 1'b1, 16'h0055, "R2 timeout 0 stores write");

    // R3/R4/R5 two expiries, reset fires
    wr(5'h10, 16'h0004, 1'b1);
    wr(5'h08, 16'h0000, 1'b1);            // consumed at E0
    wn(5);
    rd_expect(5'h00, 1'b1, 16'h0003, "R10 live count mid period");
    wn(10);                                // w15
    chk("R3 no early event", 16'(sys_event), 16'd0);
    rd_expect(5'h04, 1'b1, 16'h0000, "R3 no early expiry");
    wn(1);                                 // w16
    chk("R4 first expiry event", 16'(sys_event), 16'd1);
    chk("R4 first expiry no reset", 16'(reset_req), 16'd0);
    rd_expect(5'h04, 1'b1, 16'h0001, "R3 timeout flag");
    wn(1);
    chk("R4 event one cycle", 16'(sys_event), 16'd0);
    wn(3);                                 // w20
    rd_expect(5'h00, 1'b1, 16'h0003, "R3 reload after expiry");
    wn(11);                                // w31
    chk("R5 no early reset", 16'(reset_req), 16'd0);
    wn(1);                                 // w32
    chk("R5 reset asserted", 16'(reset_req), 16'd1);
    chk("R5 no event on reset", 16'(sys_event), 16'd0);
    rd_expect(5'h06, 1'b1, 16'h0003, "R5 second/boot flags");
    rd_expect(5'h00, 1'b1, 16'h0000, "R5 reload zero stopped");
    wn(20);
    chk("R5 reset sticky", 16'(reset_req), 16'd1);
    rd_expect(5'h00, 1'b1, 16'h0000, "R5 timer stopped");

    // R6 blocked second expiry rolls over
    do_reset();
    strap_safe = 1'b1;
    wr(5'h08, 16'h0000, 1'b1);            // E0
    wn(32);
    chk("R6 blocked no reset", 16'(reset_req), 16'd0);
    chk("R6 blocked gives event", 16'(sys_event), 16'd1);
    rd_expect(5'h06, 1'b1, 16'h0003, "R6 second flags set");
    strap_safe = 1'b0;
    event_en = 1'b0;
    wn(16);                                // w48
    chk("R6 third expiry is first", 16'(reset_req), 16'd0);
    chk("R4 event disabled", 16'(sys_event), 16'd0);
    wn(16);                                // w64
    chk("R6 fourth expiry fires", 16'(reset_req), 16'd1);

    // R7 reload write clears consecutive count
    do_reset();
    event_en = 1'b1;
    wr(5'h08, 16'h0000, 1'b1);            // E0
    wn(16);
    chk("R7 first expiry event", 16'(sys_event), 16'd1);
    wn(2);                                 // w18
    wr(5'h00, 16'hFFFF, 1'b1);            // E20
    rd_expect(5'h00, 1'b1, 16'h0004, "R7 kick restarts count");
    wn(16);                                // w36
    chk("R7 count cleared no reset", 16'(reset_req), 16'd0);
    chk("R7 expiry after kick", 16'(sys_event), 16'd1);
    wn(16);                                // w52
    chk("R7 next second fires", 16'(reset_req), 16'd1);

    // R8 halt stops, R9 lock sticky
    do_reset();
    wr(5'h08, 16'h0000, 1'b1);
    wn(5);
    wr(5'h08, 16'h0001, 1'b1);
    rd_expect(5'h00, 1'b1, 16'h0004, "R8 stopped reads stored");
    wn(30);
    rd_expect(5'h04, 1'b1, 16'h0000, "R8 no expiry after halt");
    wr(5'h08, 16'h0003, 1'b1);
    wr(5'h08, 16'h0001, 1'b1);
    rd_expect(5'h08, 1'b1, 16'h0003, "R9 lock survives write");
    wr(5'h08, 16'h0000, 1'b1);
    rd_expect(5'h08, 1'b1, 16'h0002, "R9 lock with halt cleared");
    rd_expect(5'h00, 1'b1, 16'h0004, "R8 restart on control write");

    // R11 mailboxes
    do_reset();
    event_en = 1'b0;
    wr(5'h02, 16'h0011, 1'b0);
    chk("R11 inbound event", 16'(sys_event), 16'd1);
    rd_expect(5'h04, 1'b1, 16'h0004, "R11 inbound flag");
    wr(5'h03, 16'h0022, 1'b0);
    chk("R11 outbound no event", 16'(sys_event), 16'd0);
    rd_expect(5'h04, 1'b1, 16'h0006, "R11 outbound flag");
    rd_expect(5'h02, 1'b1, 16'h2211, "R11 mailbox contents");

    wn(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule